// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block gathers level-sensitive interrupt sources into banks of 32 and merges them onto three interrupt targets: a normal interrupt line, a fast interrupt line and an endpoint line. Each bank occupies a 16-byte window on a simple register bus. The window holds a read-only view of the bank's live source levels and three enable masks, one for each target. A target output is high when any source in any bank is high and is enabled in that target's mask.

A source needs no acknowledge. Its cause bit follows the input level, so a source that drops its line stops contributing on the next cycle. The block also reports the highest-numbered source that is pending on the normal interrupt target. Banks are ranked above bits, so a handler can take sources from the top down without scanning. The number of banks is a parameter.

Top module: `irq_bank_agg`

## Requirements
- R1: After reset every mask register reads 0, all three target outputs, `pend_valid_o`, `pend_idx_o` and `reg_rdata_o` are 0.
- R2: Bank b owns byte addresses b*16 to b*16+15. Offset 0x0 is the cause register, 0x4 the normal-interrupt mask, 0x8 the fast-interrupt mask and 0xC the endpoint mask. A mask reads back the last value written to it. Read data appears on `reg_rdata_o` in the cycle after `reg_rd_i` is sampled high and holds while `reg_rd_i` is low.
- R3: A cause read of bank b returns the live source levels, where bit n is `src_i[b*32+n]`.
- R4: Writes to a cause offset are ignored and change neither the cause view nor any mask.
- R5: An address whose bank index is NUM_BANKS or higher, or whose two low bits are not zero, reads as 0. A write to such an address changes no mask.
- R6: `irq_o` is the OR over all sources of source level AND normal-interrupt mask bit. It is registered and reflects the sources and masks one clock edge after they change.
- R7: `fiq_o` follows the same rule with the fast-interrupt mask and the same one-edge latency.
- R8: `ept_o` follows the same rule with the endpoint mask and the same one-edge latency.
- R9: The three masks act independently. A mask bit of 1 lets its source reach only that mask's target, and a 0 blocks it.
- R10: `pend_valid_o` equals `irq_o`. When it is high, `pend_idx_o` = bank*32 + bit of the pending normal-interrupt source with the highest bank, and within that bank the highest bit. It has the same latency as `irq_o`.
- R11: With no acknowledge, an output falls one edge after its last enabled source goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_BANKS*32 | Level interrupt sources, bank-major |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | $clog2(NUM_BANKS*16)+1 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Normal interrupt target |
| fiq_o | output | 1 | Fast interrupt target |
| ept_o | output | 1 | Endpoint target |
| pend_valid_o | output | 1 | A normal-interrupt source is pending |
| pend_idx_o | output | $clog2(NUM_BANKS*32) | Highest pending normal-interrupt source |

## Verification
The assertions assume that `src_i` and the bus inputs are synchronous to `clk` and settled before each rising edge. Under that assumption a registered output can be related to a one-cycle-old copy of the sources. They also assume that nothing but a read strobe is meant to move `reg_rdata_o`. The stimulus changes every input on the falling edge and samples on the following falling edge, so each value seen at a rising edge was set half a period earlier. Mask writes and source changes are kept in separate phases, so the one-edge latency can be checked exactly.

// File: rtl/iagg_pkg.sv
package iagg_pkg;
    localparam int unsigned SRC_PER_BANK = 32;
    localparam int unsigned LOC_W        = $clog2(SRC_PER_BANK);
    localparam int unsigned DATA_W       = 32;
    localparam int unsigned WIN_LSB      = 4;   // 16-byte window per bank

    // Register slot inside a bank window, taken from address bits [3:2]
    typedef enum logic [1:0] {
        OFS_CAUSE    = 2'd0,
        OFS_IRQ_MASK = 2'd1,
        OFS_FIQ_MASK = 2'd2,
        OFS_EPT_MASK = 2'd3
    } win_ofs_e;

    typedef struct packed {
        logic [SRC_PER_BANK-1:0] irq;
        logic [SRC_PER_BANK-1:0] fiq;
        logic [SRC_PER_BANK-1:0] ept;
    } mask_set_t;
endpackage

// File: rtl/iagg_bank.sv
module iagg_bank
    import iagg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_PER_BANK-1:0] src_i,
    input  logic                    wr_en_i,
    input  win_ofs_e                wr_ofs_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    output mask_set_t               masks_o,
    output logic                    irq_any_o,
    output logic                    fiq_any_o,
    output logic                    ept_any_o,
    output logic                    loc_valid_o,
    output logic [LOC_W-1:0]        loc_idx_o
);
    mask_set_t masks_d, masks_q;

    logic [SRC_PER_BANK-1:0] irq_pend;
    logic [SRC_PER_BANK-1:0] fiq_pend;
    logic [SRC_PER_BANK-1:0] ept_pend;
    logic [LOC_W-1:0]        loc_idx;

    // Next-state: only mask slots accept writes; the cause slot drops them
    always_comb begin
        masks_d = masks_q;
        if (wr_en_i) begin
            case (wr_ofs_i)
                OFS_IRQ_MASK: masks_d.irq = wr_data_i;
                OFS_FIQ_MASK: masks_d.fiq = wr_data_i;
                OFS_EPT_MASK: masks_d.ept = wr_data_i;
                default:      masks_d     = masks_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            masks_q <= '0;
        end else begin
            masks_q <= masks_d;
        end
    end

    assign irq_pend = src_i & masks_q.irq;
    assign fiq_pend = src_i & masks_q.fiq;
    assign ept_pend = src_i & masks_q.ept;

    // Highest set bit wins: later iterations overwrite lower ones
    always_comb begin
        loc_idx = '0;
        for (int i = 0; i < SRC_PER_BANK; i++) begin
            if (irq_pend[i]) begin
                loc_idx = LOC_W'(i);
            end
        end
    end

    assign masks_o     = masks_q;
    assign irq_any_o   = |irq_pend;
    assign fiq_any_o   = |fiq_pend;
    assign ept_any_o   = |ept_pend;
    assign loc_valid_o = |irq_pend;
    assign loc_idx_o   = loc_idx;
endmodule

// File: rtl/iagg_prio.sv
module iagg_prio
    import iagg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned IDX_W     = $clog2(NUM_BANKS * SRC_PER_BANK)
) (
    input  logic [NUM_BANKS-1:0]       bank_valid_i,
    input  logic [NUM_BANKS*LOC_W-1:0] loc_idx_i,
    output logic                       valid_o,
    output logic [IDX_W-1:0]           idx_o
);
    // Higher banks overwrite lower ones, so the top bank takes priority
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_valid_i[b]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(b * SRC_PER_BANK)
                        + IDX_W'(loc_idx_i[b*LOC_W +: LOC_W]);
            end
        end
    end
endmodule

// File: rtl/irq_bank_agg.sv
module irq_bank_agg
    import iagg_pkg::*;
#(
    parameter  int unsigned NUM_BANKS = 2,
    localparam int unsigned NUM_SRC   = NUM_BANKS * SRC_PER_BANK,
    localparam int unsigned IDX_W     = $clog2(NUM_SRC),
    localparam int unsigned ADDR_W    = $clog2(NUM_BANKS * 16) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               ept_o,
    output logic               pend_valid_o,
    output logic [IDX_W-1:0]   pend_idx_o
);
    localparam int unsigned BSEL_W = ADDR_W - WIN_LSB;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              irq;
        logic              fiq;
        logic              ept;
        logic              pvld;
        logic [IDX_W-1:0]  pidx;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [BSEL_W-1:0] bsel;
    win_ofs_e          ofs;
    logic              aligned;

    mask_set_t                   masks_w [NUM_BANKS];
    logic [NUM_BANKS-1:0]        irq_any_w;
    logic [NUM_BANKS-1:0]        fiq_any_w;
    logic [NUM_BANKS-1:0]        ept_any_w;
    logic [NUM_BANKS-1:0]        loc_valid_w;
    logic [NUM_BANKS*LOC_W-1:0]  loc_idx_w;
    logic                        prio_valid;
    logic [IDX_W-1:0]            prio_idx;
    logic [DATA_W-1:0]           rd_mux;

    assign bsel    = reg_addr_i[ADDR_W-1:WIN_LSB];
    assign ofs     = win_ofs_e'(reg_addr_i[WIN_LSB-1:2]);
    assign aligned = (reg_addr_i[1:0] == 2'b00);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = reg_wr_i && aligned && (bsel == BSEL_W'(b));

        iagg_bank u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_i       (src_i[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .wr_en_i     (bank_wr),
            .wr_ofs_i    (ofs),
            .wr_data_i   (reg_wdata_i),
            .masks_o     (masks_w[b]),
            .irq_any_o   (irq_any_w[b]),
            .fiq_any_o   (fiq_any_w[b]),
            .ept_any_o   (ept_any_w[b]),
            .loc_valid_o (loc_valid_w[b]),
            .loc_idx_o   (loc_idx_w[b*LOC_W +: LOC_W])
        );
    end

    iagg_prio #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W)
    ) u_prio (
        .bank_valid_i (loc_valid_w),
        .loc_idx_i    (loc_idx_w),
        .valid_o      (prio_valid),
        .idx_o        (prio_idx)
    );

    // Read multiplexer: unmatched bank or misaligned address yields zero
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (aligned && (bsel == BSEL_W'(b))) begin
                case (ofs)
                    OFS_CAUSE:    rd_mux = src_i[b*SRC_PER_BANK +: SRC_PER_BANK];
                    OFS_IRQ_MASK: rd_mux = masks_w[b].irq;
                    OFS_FIQ_MASK: rd_mux = masks_w[b].fiq;
                    OFS_EPT_MASK: rd_mux = masks_w[b].ept;
                    default:      rd_mux = '0;
                endcase
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        if (reg_rd_i) begin
            st_d.rdata = rd_mux;
        end
        st_d.irq  = |irq_any_w;
        st_d.fiq  = |fiq_any_w;
        st_d.ept  = |ept_any_w;
        st_d.pvld = prio_valid;
        st_d.pidx = prio_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata_o  = st_q.rdata;
    assign irq_o        = st_q.irq;
    assign fiq_o        = st_q.fiq;
    assign ept_o        = st_q.ept;
    assign pend_valid_o = st_q.pvld;
    assign pend_idx_o   = st_q.pidx;
endmodule

// File: rtl/iagg_chk.sv
module iagg_chk
    import iagg_pkg::*;
#(
    parameter  int unsigned NUM_BANKS = 2,
    localparam int unsigned NUM_SRC   = NUM_BANKS * SRC_PER_BANK,
    localparam int unsigned IDX_W     = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               reg_rd_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               irq_o,
    input logic               fiq_o,
    input logic               ept_o,
    input logic               pend_valid_o,
    input logic [IDX_W-1:0]   pend_idx_o
);
    logic [NUM_SRC-1:0] prev_src;
    logic               started;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_src <= '0;
            started  <= 1'b0;
        end else begin
            prev_src <= src_i;
            started  <= 1'b1;
        end
    end

    AST_PEND_TRACKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o == irq_o); // R10

    AST_IDX_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |-> prev_src[pend_idx_o]); // R10

    AST_SILENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_src == '0) |-> (!irq_o && !fiq_o && !ept_o)); // R11

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !$past(reg_rd_i)) |-> $stable(reg_rdata_o)); // R2
endmodule

bind irq_bank_agg iagg_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_i        (src_i),
    .reg_rd_i     (reg_rd_i),
    .reg_rdata_o  (reg_rdata_o),
    .irq_o        (irq_o),
    .fiq_o        (fiq_o),
    .ept_o        (ept_o),
    .pend_valid_o (pend_valid_o),
    .pend_idx_o   (pend_idx_o)
);

// File: tb/irq_bank_agg_tb_top.sv
module irq_bank_agg_tb_top;
    localparam int NB = 2;
    localparam int NS = NB * 32;
    localparam int AW = $clog2(NB * 16) + 1;
    localparam int IW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq, fiq, ept, pvld;
    logic [IW-1:0] pidx;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    logic [31:0] seed = 32'h1357_9bdf;

    // Bench-side copy of the masks, updated by every legal write
    logic [NS-1:0] m_irq = '0, m_fiq = '0, m_ept = '0;

    always #10 clk = ~clk;   // 50 MHz

    irq_bank_agg #(.NUM_BANKS(NB)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src),
        .reg_wr_i     (wr),
        .reg_rd_i     (rd),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_o        (irq),
        .fiq_o        (fiq),
        .ept_o        (ept),
        .pend_valid_o (pvld),
        .pend_idx_o   (pidx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    // t: 0 normal, 1 fast, 2 endpoint
    task automatic set_mask(input int b, input int t, input logic [31:0] v);
        bus_wr(b * 16 + 4 * (t + 1), v);
        case (t)
            0: m_irq[b*32 +: 32] = v;
            1: m_fiq[b*32 +: 32] = v;
            default: m_ept[b*32 +: 32] = v;
        endcase
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Compare all registered outputs with values computed from src and shadow masks
    task automatic check_outputs(input string tag);
        logic [NS-1:0] p;
        int hi;
        p  = src & m_irq;
        hi = 0;
        for (int i = 0; i < NS; i++) if (p[i]) hi = i;
        chk({tag, " R6 irq"}, 64'(irq), 64'(|(src & m_irq)));
        chk({tag, " R7 fiq"}, 64'(fiq), 64'(|(src & m_fiq)));
        chk({tag, " R8 ept"}, 64'(ept), 64'(|(src & m_ept)));
        chk({tag, " R10 valid"}, 64'(pvld), 64'(|p));
        if (|p) chk({tag, " R10 index"}, 64'(pidx), 64'(hi));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 outputs", {59'(0), irq, fiq, ept, pvld, 1'b0}, 64'(0));
        chk("R1 pend_idx", 64'(pidx), 64'(0));
        chk("R1 rdata", 64'(rdata), 64'(0));
        for (int b = 0; b < NB; b++)
            for (int t = 1; t <= 3; t++) begin
                bus_rd(b * 16 + 4 * t, d);
                chk($sformatf("R1 mask b%0d o%0d", b, t), 64'(d), 64'(0));
            end

        // R2: mask readback per bank and slot
        for (int b = 0; b < NB; b++)
            for (int t = 0; t < 3; t++) begin
                logic [31:0] v;
                v = 32'hA5C3_0F00 ^ (32'(b) << 8) ^ (32'(t + 1) * 32'h0101_0101);
                set_mask(b, t, v);
            end
        for (int b = 0; b < NB; b++)
            for (int t = 0; t < 3; t++) begin
                logic [31:0] v;
                v = 32'hA5C3_0F00 ^ (32'(b) << 8) ^ (32'(t + 1) * 32'h0101_0101);
                bus_rd(b * 16 + 4 * (t + 1), d);
                chk($sformatf("R2 readback b%0d t%0d", b, t), 64'(d), 64'(v));
            end
        // R2: read data holds without a strobe
        keep = rdata;
        @(negedge clk); addr = AW'(0); src = {NS{1'b1}};
        repeat (3) @(negedge clk);
        chk("R2 rdata hold", 64'(rdata), 64'(keep));
        src = '0;
        for (int b = 0; b < NB; b++)
            for (int t = 0; t < 3; t++) set_mask(b, t, 32'h0);

        // R3: cause view tracks live levels
        for (int k = 0; k < 6; k++) begin
            src = {rnd(), rnd()};
            for (int b = 0; b < NB; b++) begin
                bus_rd(b * 16, d);
                chk($sformatf("R3 cause b%0d", b), 64'(d), 64'(src[b*32 +: 32]));
            end
        end

        // R4: cause writes ignored
        src = 64'h0123_4567_89AB_CDEF;
        set_mask(0, 0, 32'h0000_FFFF);
        bus_wr(0, 32'hFFFF_FFFF);
        bus_wr(16, 32'h0);
        bus_rd(0, d);
        chk("R4 cause b0", 64'(d), 64'(src[31:0]));
        bus_rd(16, d);
        chk("R4 cause b1", 64'(d), 64'(src[63:32]));
        bus_rd(4, d);
        chk("R4 mask intact", 64'(d), 64'(32'h0000_FFFF));
        set_mask(0, 0, 32'h0);

        // R5: undefined addresses
        for (int a = NB * 16; a < (1 << AW); a += 4) begin
            bus_rd(a, d);
            chk($sformatf("R5 read %0h", a), 64'(d), 64'(0));
        end
        for (int a = 5; a < 8; a++) begin
            bus_rd(a, d);
            chk($sformatf("R5 misaligned %0h", a), 64'(d), 64'(0));
        end
        src = {NS{1'b1}};
        bus_wr(NB * 16 + 4, 32'hFFFF_FFFF);
        bus_wr(5, 32'hFFFF_FFFF);
        bus_wr(NB * 16 + 8, 32'hFFFF_FFFF);
        bus_rd(4, d);
        chk("R5 no alias mask", 64'(d), 64'(0));
        @(negedge clk);
        chk("R5 outputs quiet", {61'(0), irq, fiq, ept}, 64'(0));

        // R6 R7 R8 R9: one-hot sweep of every source on every target
        src = '0;
        for (int s = 0; s < NS; s++)
            for (int t = 0; t < 3; t++) begin
                set_mask(s / 32, t, 32'(1) << (s % 32));
                src = NS'(1) << s;
                @(negedge clk);
                check_outputs($sformatf("R9 s%0d t%0d on", s, t));
                src = ~(NS'(1) << s);
                @(negedge clk);
                check_outputs($sformatf("R9 s%0d t%0d others", s, t));
                src = '0;
                set_mask(s / 32, t, 32'h0);
            end

        // R10: directed priority cases
        set_mask(0, 0, 32'hFFFF_FFFF);
        set_mask(1, 0, 32'hFFFF_FFFF);
        src = 64'h0000_0001_8000_0001;
        @(negedge clk);
        chk("R10 upper bank wins", 64'(pidx), 64'(32));
        src = 64'h0000_0000_8000_0001;
        @(negedge clk);
        chk("R10 top bit wins", 64'(pidx), 64'(31));

        // R6 R11: exact latency and fall without acknowledge
        src = 64'h0000_0000_0000_0010;
        @(negedge clk);
        chk("R11 rise", 64'(irq), 64'(1));
        src = '0;
        #1;
        chk("R6 holds before edge", 64'(irq), 64'(1));
        @(negedge clk);
        chk("R11 fall", 64'(irq), 64'(0));
        chk("R11 valid fall", 64'(pvld), 64'(0));

        // R10 R6 R7 R8: random masks and sources
        for (int k = 0; k < 150; k++) begin
            for (int b = 0; b < NB; b++)
                for (int t = 0; t < 3; t++) set_mask(b, t, rnd() & rnd());
            src = {rnd() & rnd(), rnd() & rnd()};
            @(negedge clk);
            check_outputs($sformatf("R10 random %0d", k));
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule